// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block listens to the four lines of an SPI link (serial clock, the two data lines and chip select) without driving any of them. It runs on a system clock at least four times faster than the serial clock. Every line passes through a synchroniser. The block then finds the serial clock edge on which data is valid for the configured clock mode. On each such edge it captures one bit from each data line.

When a word of the configured length is complete, the block emits a single-cycle record. The record holds the controller-to-peripheral word, the peripheral-to-controller word, the cycle stamps of the word's first and last bits, and a flag that is set if chip select was not active on any bit of the word. Separately, each change of the chip-select line produces a single-cycle event with the previous level, the new level and a cycle stamp. A saturating counter tracks completed words. Clock mode, bit order, word length and chip-select polarity are run-time inputs.

Top module: `spi_bus_monitor`

## Requirements
- R1: The clock mode is {cpol, cpha}. Modes 0 and 3 capture data when the synchronised serial clock goes from 0 to 1. Modes 1 and 2 capture data when it goes from 1 to 0. Transitions in the other direction capture nothing.
- R2: With lsbFirst = 0, the k-th captured bit (k counting from 0) of a word of length W is placed at bit W-1-k of both output words.
- R3: With lsbFirst = 1, the k-th captured bit is placed at bit k of both output words.
- R4: wordLen takes values from 1 to 64. Both words complete together on the wordLen-th capture edge, and exactly one record is emitted per word.
- R5: startTs is the cycle stamp of the first capture of the word and endTs is that of the last capture, so endTs - startTs equals the number of system cycles between those two capture edges. A one-bit word has startTs = endTs.
- R6: warn is 1 exactly when chip select was inactive at any capture of the word. Active means level 0 when csActHigh = 0 and level 1 when csActHigh = 1. The flag does not carry over into the next word.
- R7: Each change of the synchronised chip-select level raises csEvt for one cycle, with csOld and csNew giving the levels before and after the change. csTs stamps the change on the same time base as the word stamps, so that chip select and a capture edge with equal latency get the same stamp.
- R8: After a record is emitted, the capture state is cleared, so a following word does not inherit set bits from an earlier one.
- R9: wordCount rises by one with each record and holds at its all-ones value instead of wrapping.
- R10: After reset there are no records and no events, and all output words and wordCount are 0. The remembered chip-select level starts at the inactive level, so an idle inactive line produces no event.
- R11: wordValid is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sckIn | input | 1 | Serial clock line |
| mosiIn | input | 1 | Controller-to-peripheral data line |
| misoIn | input | 1 | Peripheral-to-controller data line |
| csIn | input | 1 | Chip-select line |
| cpol | input | 1 | Idle level of the serial clock (upper mode bit) |
| cpha | input | 1 | Clock phase (lower mode bit) |
| lsbFirst | input | 1 | 1: first bit is the least significant |
| csActHigh | input | 1 | 1: chip select is active at level 1 |
| wordLen | input | 7 | Word length in bits, 1 to 64 |
| wordValid | output | 1 | One-cycle pulse: a word record is present |
| mosiWord | output | 64 | Captured controller-to-peripheral word |
| misoWord | output | 64 | Captured peripheral-to-controller word |
| startTs | output | 32 | Stamp of the word's first capture |
| endTs | output | 32 | Stamp of the word's last capture |
| warn | output | 1 | Chip select was inactive during the word |
| csEvt | output | 1 | One-cycle pulse: chip-select level changed |
| csOld | output | 1 | Chip-select level before the change |
| csNew | output | 1 | Chip-select level after the change |
| csTs | output | 32 | Stamp of the chip-select change |
| wordCount | output | 16 | Saturating count of completed words |

## Verification
A word record and a chip-select event can occur in the same cycle. This happens when chip select is released on the very system cycle on which the final capture edge of a word arrives. The bench provokes this by driving the release and the last leading clock edge on the same cycle, so that both pass through synchronisers of equal depth. It then requires wordValid and csEvt to be high together, warn to be set on that word, the event to show active-to-inactive, and both data words to be intact.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int MAX_WORD = 64;
  localparam int POS_W = $clog2(MAX_WORD);

  // strobes from control to datapath, one set per system cycle
  typedef struct packed {
    logic             sample;   // a capture edge is in this cycle
    logic             first;    // it carries bit 0 of a word
    logic             last;     // it carries the final bit of a word
    logic [POS_W-1:0] bitPos;   // destination index of the bit
    logic             mosiBit;
    logic             misoBit;
    logic             csInact;  // chip select inactive at this capture
    logic             csChg;    // chip select level changed
    logic             csOldVal;
    logic             csNewVal;
  } monStrobe_t;
endpackage

// File: rtl/spi_mon_ctrl.sv
module spi_mon_ctrl
  import spi_mon_pkg::*;
#(
  parameter int MAX_W    = MAX_WORD,
  parameter int SYNC_LEN = 2,
  localparam int LEN_W   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sckIn,
  input  logic             mosiIn,
  input  logic             misoIn,
  input  logic             csIn,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsbFirst,
  input  logic             csActHigh,
  input  logic [LEN_W-1:0] wordLen,
  output monStrobe_t       strobe
);
  logic [SYNC_LEN-1:0] sckSy, mosiSy, misoSy, csSy;
  logic sckPrev, csPrev;
  logic [POS_W-1:0] bitCnt;
  logic sckNow, csNow, csIdle, sampleEdge, isLast;
  logic [LEN_W-1:0] lenEff, lastIdx;

  assign csIdle = ~csActHigh;
  assign sckNow = sckSy[SYNC_LEN-1];
  assign csNow  = csSy[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sckSy   <= {SYNC_LEN{cpol}};
      csSy    <= {SYNC_LEN{csIdle}};
      mosiSy  <= '0;
      misoSy  <= '0;
      sckPrev <= cpol;
      csPrev  <= csIdle;
      bitCnt  <= '0;
    end else begin
      sckSy   <= {sckSy[SYNC_LEN-2:0], sckIn};
      csSy    <= {csSy[SYNC_LEN-2:0], csIn};
      mosiSy  <= {mosiSy[SYNC_LEN-2:0], mosiIn};
      misoSy  <= {misoSy[SYNC_LEN-2:0], misoIn};
      sckPrev <= sckNow;
      csPrev  <= csNow;
      if (sampleEdge) bitCnt <= isLast ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    // modes 0 and 3 capture on rise, 1 and 2 on fall
    if (cpol ^ cpha) sampleEdge = sckPrev & ~sckNow;
    else             sampleEdge = ~sckPrev & sckNow;
    if (wordLen == '0 || wordLen > LEN_W'(MAX_W)) lenEff = LEN_W'(MAX_W);
    else                                           lenEff = wordLen;
    lastIdx = lenEff - 1'b1;
    isLast  = (LEN_W'(bitCnt) == lastIdx);

    strobe.sample   = sampleEdge;
    strobe.first    = sampleEdge && (bitCnt == '0);
    strobe.last     = sampleEdge && isLast;
    strobe.bitPos   = lsbFirst ? bitCnt : POS_W'(lastIdx) - bitCnt;
    strobe.mosiBit  = mosiSy[SYNC_LEN-1];
    strobe.misoBit  = misoSy[SYNC_LEN-1];
    strobe.csInact  = csActHigh ? ~csNow : csNow;
    strobe.csChg    = (csNow != csPrev);
    strobe.csOldVal = csPrev;
    strobe.csNewVal = csNow;
  end
endmodule

// File: rtl/spi_mon_dpath.sv
module spi_mon_dpath
  import spi_mon_pkg::*;
#(
  parameter int MAX_W = MAX_WORD,
  parameter int TS_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  monStrobe_t       strobe,
  output logic             wordValid,
  output logic [MAX_W-1:0] mosiWord,
  output logic [MAX_W-1:0] misoWord,
  output logic [TS_W-1:0]  startTs,
  output logic [TS_W-1:0]  endTs,
  output logic             warn,
  output logic             csEvt,
  output logic             csOld,
  output logic             csNew,
  output logic [TS_W-1:0]  csTs,
  output logic [CNT_W-1:0] wordCount
);
  logic [TS_W-1:0]  tsCnt, startLatch, startSel;
  logic [MAX_W-1:0] mosiAcc, misoAcc, posMask, mosiNext, misoNext;
  logic             warnAcc, warnNext;

  always_comb begin
    posMask  = MAX_W'(1) << strobe.bitPos;
    mosiNext = mosiAcc | (strobe.mosiBit ? posMask : '0);
    misoNext = misoAcc | (strobe.misoBit ? posMask : '0);
    warnNext = (strobe.first ? 1'b0 : warnAcc) | strobe.csInact;
    startSel = strobe.first ? tsCnt : startLatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsCnt <= '0; startLatch <= '0; mosiAcc <= '0; misoAcc <= '0; warnAcc <= 1'b0;
      wordValid <= 1'b0; mosiWord <= '0; misoWord <= '0; startTs <= '0; endTs <= '0;
      warn <= 1'b0; csEvt <= 1'b0; csOld <= 1'b0; csNew <= 1'b0; csTs <= '0;
      wordCount <= '0;
    end else begin
      tsCnt     <= tsCnt + 1'b1;
      wordValid <= 1'b0;
      csEvt     <= 1'b0;
      if (strobe.csChg) begin
        csEvt <= 1'b1;
        csOld <= strobe.csOldVal;
        csNew <= strobe.csNewVal;
        csTs  <= tsCnt;
      end
      if (strobe.sample) begin
        if (strobe.last) begin
          wordValid <= 1'b1;
          mosiWord  <= mosiNext;
          misoWord  <= misoNext;
          startTs   <= startSel;
          endTs     <= tsCnt;
          warn      <= warnNext;
          mosiAcc   <= '0;
          misoAcc   <= '0;
          warnAcc   <= 1'b0;
          if (wordCount != '1) wordCount <= wordCount + 1'b1;
        end else begin
          mosiAcc    <= mosiNext;
          misoAcc    <= misoNext;
          warnAcc    <= warnNext;
          startLatch <= startSel;
        end
      end
    end
  end
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
  import spi_mon_pkg::*;
#(
  parameter int MAX_W    = MAX_WORD,
  parameter int TS_W     = 32,
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 2,
  localparam int LEN_W   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sckIn,
  input  logic             mosiIn,
  input  logic             misoIn,
  input  logic             csIn,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsbFirst,
  input  logic             csActHigh,
  input  logic [LEN_W-1:0] wordLen,
  output logic             wordValid,
  output logic [MAX_W-1:0] mosiWord,
  output logic [MAX_W-1:0] misoWord,
  output logic [TS_W-1:0]  startTs,
  output logic [TS_W-1:0]  endTs,
  output logic             warn,
  output logic             csEvt,
  output logic             csOld,
  output logic             csNew,
  output logic [TS_W-1:0]  csTs,
  output logic [CNT_W-1:0] wordCount
);
  monStrobe_t strobe;

  spi_mon_ctrl #(.MAX_W(MAX_W), .SYNC_LEN(SYNC_LEN)) ctrl (
    .clk(clk), .rst(rst), .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .csIn(csIn), .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst),
    .csActHigh(csActHigh), .wordLen(wordLen), .strobe(strobe)
  );

  spi_mon_dpath #(.MAX_W(MAX_W), .TS_W(TS_W), .CNT_W(CNT_W)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wordValid(wordValid),
    .mosiWord(mosiWord), .misoWord(misoWord), .startTs(startTs), .endTs(endTs),
    .warn(warn), .csEvt(csEvt), .csOld(csOld), .csNew(csNew), .csTs(csTs),
    .wordCount(wordCount)
  );
endmodule

// File: rtl/spi_bus_monitor_chk.sv
module spi_bus_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wordValid,
  input logic             csEvt,
  input logic             csOld,
  input logic             csNew,
  input logic [CNT_W-1:0] wordCount
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // R11: a record never lasts two cycles
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  // R7: an event always reports a real level change
  a_r7_levels_differ: assert property (@(posedge clk) disable iff (rst)
    csEvt |-> (csOld != csNew));

  // R9: count steps with each record and saturates
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (wordCount == (($past(wordCount) == CNT_TOP) ? CNT_TOP
                                 : $past(wordCount) + 1'b1)));

  // R9: count is still between records
  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(wordCount));
endmodule

bind spi_bus_monitor spi_bus_monitor_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst(rst), .wordValid(wordValid), .csEvt(csEvt),
  .csOld(csOld), .csNew(csNew), .wordCount(wordCount)
);

// File: tb/spi_bus_monitor_test.sv
module spi_bus_monitor_test;
  localparam int MW = 64;
  localparam int TW = 32;
  localparam int CW = 3;
  localparam int HALF = 4; // system cycles per serial clock half period

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic rst, sckIn, mosiIn, misoIn, csIn, cpol, cpha, lsbFirst, csActHigh;
  logic [6:0] wordLen;
  logic wordValid, warn, csEvt, csOld, csNew;
  logic [MW-1:0] mosiWord, misoWord;
  logic [TW-1:0] startTs, endTs, csTs;
  logic [CW-1:0] wordCount;

  spi_bus_monitor #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .csIn(csIn), .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst),
    .csActHigh(csActHigh), .wordLen(wordLen), .wordValid(wordValid),
    .mosiWord(mosiWord), .misoWord(misoWord), .startTs(startTs), .endTs(endTs),
    .warn(warn), .csEvt(csEvt), .csOld(csOld), .csNew(csNew), .csTs(csTs),
    .wordCount(wordCount)
  );

  int nTests = 0;
  int nFail = 0;
  int expWords = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // monitor, sampling away from the active edge
  logic [MW-1:0] gotMosi, gotMiso;
  logic [TW-1:0] gotStart, gotEnd, evtTs;
  logic gotWarn, gotTogether, evtOld, evtNew, prevValid;
  int gotWords = 0;
  int evtCount = 0;
  initial prevValid = 1'b0;
  always @(negedge clk) begin
    if (wordValid) begin
      gotWords++;
      gotMosi = mosiWord; gotMiso = misoWord;
      gotStart = startTs; gotEnd = endTs;
      gotWarn = warn; gotTogether = csEvt;
      if (prevValid) check(1'b0, "R11 record longer than one cycle", 64'd2, 64'd1);
    end
    if (csEvt) begin
      evtCount++;
      evtOld = csOld; evtNew = csNew; evtTs = csTs;
    end
    prevValid = wordValid;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendWord(input bit cp, input bit ch, input bit lsb, input bit ah,
                          input int len, input logic [63:0] mv, input logic [63:0] sv,
                          input bit dropLast, input bit noCs, input string tag);
    int w0 = gotWords;
    logic act = ah;
    logic inact = ~ah;
    logic [63:0] mask = (len == 64) ? '1 : ((64'd1 << len) - 64'd1);
    logic [TW-1:0] assertTs;
    @(negedge clk);
    cpol = cp; cpha = ch; lsbFirst = lsb; csActHigh = ah;
    sckIn = cp; wordLen = 7'(len); csIn = inact;
    waitCyc(6);
    if (!noCs) csIn = act;
    waitCyc(2);
    for (int k = 0; k < len; k++) begin
      logic b = lsb ? mv[k] : mv[len-1-k];
      logic bm = lsb ? sv[k] : sv[len-1-k];
      if (!ch) begin
        mosiIn = b; misoIn = bm;
        waitCyc(HALF);
        sckIn = ~cp;
        if (dropLast && k == len - 1) csIn = inact;
        waitCyc(HALF);
        sckIn = cp;
      end else begin
        sckIn = ~cp; mosiIn = b; misoIn = bm;
        waitCyc(HALF);
        sckIn = cp;
        waitCyc(HALF);
      end
    end
    assertTs = evtTs;
    waitCyc(5);
    expWords++;
    check(gotWords == w0 + 1, {tag, " R4 one record per word"}, 64'(gotWords - w0), 64'd1);
    check(gotMosi == (mv & mask), {tag, " mosi word"}, gotMosi, mv & mask);
    check(gotMiso == (sv & mask), {tag, " miso word"}, gotMiso, sv & mask);
    check(gotEnd - gotStart == TW'((len - 1) * 2 * HALF), {tag, " R5 end-start"},
          64'(gotEnd - gotStart), 64'((len - 1) * 2 * HALF));
    if (!noCs && !dropLast)
      check(gotStart - assertTs == TW'(HALF + 2), {tag, " R5 R7 start vs cs stamp"},
            64'(gotStart - assertTs), 64'(HALF + 2));
    check(gotWarn == (noCs | dropLast), {tag, " R6 warn"}, 64'(gotWarn), 64'(noCs | dropLast));
    check(wordCount == CW'((expWords > 7) ? 7 : expWords), {tag, " R9 count"},
          64'(wordCount), 64'((expWords > 7) ? 7 : expWords));
    if (dropLast) begin
      check(gotTogether == 1'b1, {tag, " R7 event with record"}, 64'(gotTogether), 64'd1);
      check(evtOld == act && evtNew == inact, {tag, " R7 old/new"},
            64'({evtOld, evtNew}), 64'({act, inact}));
    end
    csIn = inact;
    waitCyc(6);
  endtask

  task automatic tReset();
    waitCyc(6);
    check(wordValid == 1'b0, "R10 no record after reset", 64'(wordValid), 64'd0);
    check(evtCount == 0, "R10 no event from idle cs", 64'(evtCount), 64'd0);
    check(wordCount == '0, "R10 count zero", 64'(wordCount), 64'd0);
    check(mosiWord == '0 && misoWord == '0, "R10 words zero", mosiWord | misoWord, 64'd0);
  endtask

  task automatic tFirstEvent();
    int e0 = evtCount;
    @(negedge clk); csIn = 1'b0;
    waitCyc(5);
    check(evtCount == e0 + 1, "R7 single event on assert", 64'(evtCount - e0), 64'd1);
    check(evtOld == 1'b1 && evtNew == 1'b0, "R7 levels on assert", 64'({evtOld, evtNew}), 64'b10);
    csIn = 1'b1;
    waitCyc(5);
  endtask

  initial begin
    rst = 1'b1; sckIn = 1'b0; mosiIn = 1'b0; misoIn = 1'b0; csIn = 1'b1;
    cpol = 1'b0; cpha = 1'b0; lsbFirst = 1'b0; csActHigh = 1'b0; wordLen = 7'd8;
    waitCyc(4);
    rst = 1'b0;
    tReset();
    tFirstEvent();
    sendWord(0, 0, 0, 0, 8, 64'hA5, 64'h3C, 0, 0, "R1 R2 mode0 msb");
    sendWord(0, 1, 1, 0, 8, 64'h96, 64'h01, 0, 0, "R1 R3 mode1 lsb");
    sendWord(1, 0, 0, 0, 12, 64'hABC, 64'h5A3, 0, 0, "R1 R2 mode2 len12");
    sendWord(1, 1, 1, 0, 64, 64'hF00D_1234_9876_C0DE, 64'h0123_4567_89AB_CDEF, 0, 0,
             "R1 R3 R4 mode3 len64");
    sendWord(0, 0, 0, 0, 1, 64'h1, 64'h0, 0, 0, "R4 R5 len1");
    sendWord(0, 0, 0, 0, 8, 64'hFF, 64'hFF, 0, 0, "R8 all ones");
    sendWord(0, 0, 0, 0, 8, 64'h00, 64'h00, 0, 0, "R8 cleared");
    sendWord(0, 0, 0, 0, 8, 64'h5C, 64'hE1, 1, 0, "R6 R7 cs drop on last edge");
    sendWord(0, 0, 0, 1, 8, 64'h5A, 64'hC3, 0, 0, "R6 active-high, flag cleared");
    sendWord(0, 0, 0, 1, 8, 64'h33, 64'hCC, 0, 1, "R6 R9 cs inactive all word");
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end
endmodule